// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which physical frame to give up when a new page must be brought in. It keeps two flags for every frame: a "recently referenced" flag and a "modified" flag. It also keeps a pointer to the frame it chose last time. Each load or store to a frame is reported on the reference port. A load marks the frame as referenced. A store marks it as referenced and modified.

When a replacement is requested, the block visits the frames one per clock cycle. It starts at the frame after the pointer and wraps around the end of the table. Any referenced frame it passes loses its referenced flag, which gives that frame a second chance. The block stops at the first frame that qualifies. It reports that frame on `victim_idx` together with a one-cycle `done` pulse, and the pointer then stays on that frame.

An optional clean-preferring mode accepts only frames that are both unreferenced and unmodified. If a whole lap of the table finds no such frame, it falls back to the first unreferenced frame seen during that lap. The selected frame is taken to be refilled with a fresh page, so its modified flag is cleared.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all referenced and modified flags are 0. `busy` and `done` are 0 and `victim_idx` is 0. The pointer rests on the last frame, so the first search visits frame 0 first.
- R2: A reference with `ref_write`=0 (load) sets the referenced flag of frame `ref_idx`. A reference with `ref_write`=1 (store) sets both its referenced and modified flags. A load leaves the modified flag unchanged.
- R3: A request is taken only when `busy` is 0. The search then visits frames starting one past the pointer, one frame per cycle, wrapping from frame NFRAMES-1 to frame 0.
- R4: In normal mode (`clean_pref`=0) the first visited frame whose referenced flag is 0 is chosen. Every referenced frame passed on the way has its flag cleared.
- R5: `done` is high for exactly one cycle, in the cycle after the chosen frame was visited. At that point `victim_idx` shows the chosen frame and holds it until the next choice. The pointer moves to the chosen frame. With k frames visited, `done` is first seen k cycles after the cycle in which the request was taken.
- R6: In clean-preferring mode (`clean_pref`=1 when the request is taken) the first visited frame that is both unreferenced and unmodified is chosen.
- R7: In clean-preferring mode, if a lap of NFRAMES visits finds no unreferenced, unmodified frame, the first unreferenced frame seen in that lap is chosen at the end of the lap. If the lap saw no unreferenced frame at all, the search runs one more lap under the same rules.
- R8: Choosing a frame clears its modified flag.
- R9: A reference that lands on the frame the search is clearing in that same cycle wins, and the frame's referenced flag stays set.
- R10: Requests raised while `busy` is 1 are ignored. They neither restart nor extend the search.
- R11: If no reference arrives during a search, `done` follows within 2·NFRAMES visited frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_idx | input | IDX_W | Referenced frame |
| ref_write | input | 1 | Reference is a store (also marks the frame modified) |
| req_valid | input | 1 | Request to choose a victim frame |
| clean_pref | input | 1 | Prefer unreferenced and unmodified frames (sampled with the request) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: `victim_idx` is valid |
| victim_idx | output | IDX_W | Chosen frame |

## Verification
A referenced flag that is wrong inside the block shows up at the ports on the next search that reaches that frame. The search either stops one frame early or late, or takes a different number of cycles, so `victim_idx` and the delay from request to `done` both differ from the expected values. A modified flag that is stuck or never cleared appears only in clean-preferring mode: the chosen frame moves and the lap-end fallback fires at a different cycle. A pointer that is misplaced shifts the start of the very next search, so the first request after the fault already reports another frame.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_st_e;

  // Next frame on the clock face, wrapping at n.
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // A frame qualifies when unreferenced and, in clean mode, unmodified.
  function automatic logic frame_qualifies(input logic used, input logic dirty, input logic clean_mode);
    return !used && (!clean_mode || !dirty);
  endfunction

endpackage

// File: rtl/clkrep_flags.sv
module clkrep_flags #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid,
  input  logic [IDX_W-1:0]   ref_idx,
  input  logic               ref_write,
  input  logic               clr_used_en,
  input  logic [IDX_W-1:0]   clr_used_idx,
  input  logic               clr_dirty_en,
  input  logic [IDX_W-1:0]   clr_dirty_idx,
  output logic [NFRAMES-1:0] used_vec,
  output logic [NFRAMES-1:0] dirty_vec
);

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic hit_ref, hit_clr, hit_pick;

    assign hit_ref  = ref_valid && (ref_idx == MY_IDX);
    assign hit_clr  = clr_used_en && (clr_used_idx == MY_IDX);
    assign hit_pick = clr_dirty_en && (clr_dirty_idx == MY_IDX);

    // A reference outranks the sweep clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n)       used_vec[g] <= 1'b0;
      else if (hit_ref) used_vec[g] <= 1'b1;
      else if (hit_clr) used_vec[g] <= 1'b0;
    end

    // A store outranks the clear that comes with being chosen.
    always_ff @(posedge clk) begin
      if (!rst_n)                     dirty_vec[g] <= 1'b0;
      else if (hit_ref && ref_write)  dirty_vec[g] <= 1'b1;
      else if (hit_pick)              dirty_vec[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/clkrep_sweep.sv
module clkrep_sweep
  import clkrep_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               clean_pref,
  input  logic [NFRAMES-1:0] used_vec,
  input  logic [NFRAMES-1:0] dirty_vec,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               clr_en,
  output logic [IDX_W-1:0]   clr_idx,
  output logic               pick_en,
  output logic [IDX_W-1:0]   pick_idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

  sweep_st_e        st;
  logic [IDX_W-1:0] cur, ptr, step, fb_idx;
  logic             fb_valid, mode_clean;

  logic             searching, cur_used, cur_dirty, cand_ok, lap_end;
  logic             fb_now_valid;
  logic [IDX_W-1:0] fb_now_idx;

  assign searching    = (st == ST_SWEEP);
  assign cur_used     = used_vec[cur];
  assign cur_dirty    = dirty_vec[cur];
  assign cand_ok      = frame_qualifies(cur_used, cur_dirty, mode_clean);
  assign lap_end      = (step == LAST);
  assign fb_now_valid = fb_valid || !cur_used;
  assign fb_now_idx   = fb_valid ? fb_idx : cur;

  assign pick_en  = searching && (cand_ok || (mode_clean && lap_end && fb_now_valid));
  assign pick_idx = cand_ok ? cur : fb_now_idx;
  assign clr_en   = searching && cur_used;
  assign clr_idx  = cur;
  assign busy     = searching;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur        <= '0;
      ptr        <= LAST;
      step       <= '0;
      fb_idx     <= '0;
      fb_valid   <= 1'b0;
      mode_clean <= 1'b0;
      done       <= 1'b0;
      victim_idx <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st         <= ST_SWEEP;
            cur        <= IDX_W'(wrap_next(int'(ptr), NFRAMES));
            step       <= '0;
            fb_valid   <= 1'b0;
            mode_clean <= clean_pref;
          end
        end
        ST_SWEEP: begin
          if (pick_en) begin
            st         <= ST_IDLE;
            done       <= 1'b1;
            victim_idx <= pick_idx;
            ptr        <= pick_idx;
          end else begin
            cur  <= IDX_W'(wrap_next(int'(cur), NFRAMES));
            step <= lap_end ? '0 : step + 1'b1;
            if (lap_end) begin
              fb_valid <= 1'b0;
            end else if (mode_clean && !cur_used && !fb_valid) begin
              fb_valid <= 1'b1;
              fb_idx   <= cur;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter  int NFRAMES = 8,
  localparam int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             ref_write,
  input  logic             req_valid,
  input  logic             clean_pref,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx
);

  // Internal events, named for the bound checker.
  logic [NFRAMES-1:0] used_vec, dirty_vec;
  logic               sweep_clr_en, pick_en;
  logic [IDX_W-1:0]   sweep_idx, pick_idx;

  clkrep_flags #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_valid     (ref_valid),
    .ref_idx       (ref_idx),
    .ref_write     (ref_write),
    .clr_used_en   (sweep_clr_en),
    .clr_used_idx  (sweep_idx),
    .clr_dirty_en  (pick_en),
    .clr_dirty_idx (pick_idx),
    .used_vec      (used_vec),
    .dirty_vec     (dirty_vec)
  );

  clkrep_sweep #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .clean_pref (clean_pref),
    .used_vec   (used_vec),
    .dirty_vec  (dirty_vec),
    .busy       (busy),
    .done       (done),
    .victim_idx (victim_idx),
    .clr_en     (sweep_clr_en),
    .clr_idx    (sweep_idx),
    .pick_en    (pick_en),
    .pick_idx   (pick_idx)
  );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_valid,
  input logic [IDX_W-1:0]   ref_idx,
  input logic               ref_write,
  input logic               req_valid,
  input logic               busy,
  input logic               done,
  input logic [IDX_W-1:0]   victim_idx,
  input logic [NFRAMES-1:0] used_vec,
  input logic [NFRAMES-1:0] dirty_vec,
  input logic               sweep_clr_en,
  input logic [IDX_W-1:0]   sweep_idx,
  input logic               pick_en,
  input logic [IDX_W-1:0]   pick_idx
);

  localparam int CW = $clog2(2 * NFRAMES + 2) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(2 * NFRAMES);

  logic [CW-1:0] visits;
  logic          quiet;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      visits <= '0;
      quiet  <= 1'b1;
    end else begin
      visits <= visits + 1'b1;
      quiet  <= quiet && !ref_valid;
    end
  end

  AST_REF_SETS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> used_vec[$past(ref_idx)]); // R2
  AST_STORE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_write) |=> dirty_vec[$past(ref_idx)]); // R2
  AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy); // R3
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_clr_en && !(ref_valid && ref_idx == sweep_idx)) |=> !used_vec[$past(sweep_idx)]); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_PICK_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en |=> (done && !busy && victim_idx == $past(pick_idx))); // R5
  AST_PICK_CLEANS: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_en && !(ref_valid && ref_write && ref_idx == pick_idx)) |=> !dirty_vec[$past(pick_idx)]); // R8
  AST_REF_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_clr_en && ref_valid && ref_idx == sweep_idx) |=> used_vec[$past(sweep_idx)]); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pick_en) |=> busy); // R10
  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && quiet) |-> (visits < LIMIT)); // R11

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_valid    (ref_valid),
  .ref_idx      (ref_idx),
  .ref_write    (ref_write),
  .req_valid    (req_valid),
  .busy         (busy),
  .done         (done),
  .victim_idx   (victim_idx),
  .used_vec     (used_vec),
  .dirty_vec    (dirty_vec),
  .sweep_clr_en (sweep_clr_en),
  .sweep_idx    (sweep_idx),
  .pick_en      (pick_en),
  .pick_idx     (pick_idx)
);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;

  localparam int NF = 8;
  localparam int IW = 3;
  localparam int NV = 26;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_RQ = 2'd2, OP_RC = 2'd3;

  // {op, frame, expected victim, expected frames visited}
  localparam logic [12:0] VECS [NV] = '{
    {OP_RQ, 3'd0, 3'd0, 5'd1},
    {OP_LD, 3'd1, 3'd0, 5'd0}, {OP_LD, 3'd2, 3'd0, 5'd0}, {OP_ST, 3'd3, 3'd0, 5'd0},
    {OP_RQ, 3'd0, 3'd4, 5'd4},
    {OP_LD, 3'd5, 3'd0, 5'd0}, {OP_LD, 3'd6, 3'd0, 5'd0}, {OP_LD, 3'd7, 3'd0, 5'd0},
    {OP_LD, 3'd0, 3'd0, 5'd0}, {OP_LD, 3'd1, 3'd0, 5'd0}, {OP_LD, 3'd2, 3'd0, 5'd0},
    {OP_ST, 3'd3, 3'd0, 5'd0}, {OP_LD, 3'd4, 3'd0, 5'd0},
    {OP_RQ, 3'd0, 3'd5, 5'd9},
    {OP_ST, 3'd6, 3'd0, 5'd0}, {OP_ST, 3'd7, 3'd0, 5'd0},
    {OP_RC, 3'd0, 3'd0, 5'd3},
    {OP_ST, 3'd1, 3'd0, 5'd0}, {OP_ST, 3'd2, 3'd0, 5'd0},
    {OP_RC, 3'd0, 3'd4, 5'd4},
    {OP_ST, 3'd5, 3'd0, 5'd0}, {OP_ST, 3'd0, 3'd0, 5'd0}, {OP_ST, 3'd4, 3'd0, 5'd0},
    {OP_RC, 3'd0, 3'd6, 5'd8},
    {OP_RQ, 3'd0, 3'd7, 5'd1},
    {OP_RC, 3'd0, 3'd6, 5'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0, ref_write = 1'b0, req_valid = 1'b0, clean_pref = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic busy, done;
  logic [IW-1:0] victim_idx;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clock_victim_sel #(.NFRAMES(NF)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .ref_write(ref_write), .req_valid(req_valid), .clean_pref(clean_pref),
    .busy(busy), .done(done), .victim_idx(victim_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_ref(input int idx, input bit wr);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = IW'(idx); ref_write = wr;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  // k = number of cycles from the request to the first sample with done high
  task automatic do_req(input bit cl, output int k);
    @(negedge clk);
    req_valid = 1'b1; clean_pref = cl;
    @(negedge clk);
    req_valid = 1'b0; clean_pref = 1'b0;
    k = 0;
    while (!done && k < 64) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, dones, last_v;
    do_reset();
    // R1: reset state at the ports
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(victim_idx == '0, "R1 victim after reset", int'(victim_idx), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VECS[v][12:11];
      if (op == OP_LD || op == OP_ST) begin
        do_ref(int'(VECS[v][10:8]), op == OP_ST);
      end else begin
        do_req(op == OP_RC, k);
        check(done == 1'b1 && victim_idx == VECS[v][7:5],
              $sformatf("R4/R6/R7/R8 vector %0d victim", v), int'(victim_idx), int'(VECS[v][7:5]));
        check(k == int'(VECS[v][4:0]),
              $sformatf("R3/R5 vector %0d latency", v), k, int'(VECS[v][4:0]));
        check(k <= 2 * NF, $sformatf("R11 vector %0d bound", v), k, 2 * NF);
        @(negedge clk);
        check(done == 1'b0, $sformatf("R5 vector %0d pulse width", v), int'(done), 0);
        check(victim_idx == VECS[v][7:5], $sformatf("R5 vector %0d hold", v),
              int'(victim_idx), int'(VECS[v][7:5]));
      end
    end

    // R10: a request raised while busy is ignored
    do_reset();
    for (int f = 0; f < NF; f++) do_ref(f, 1'b0);
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    dones = 0; last_v = -1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done) begin dones++; last_v = int'(victim_idx); end
    end
    check(dones == 1, "R10 single done", dones, 1);
    check(last_v == 0, "R10 victim", last_v, 0);

    // R9: reference to frame 0 in the cycle the sweep clears it
    do_reset();
    for (int f = 0; f < NF; f++) do_ref(f, 1'b0);
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0; ref_valid = 1'b1; ref_idx = '0; ref_write = 1'b0;
    @(negedge clk); ref_valid = 1'b0;
    k = 1;
    while (!done && k < 64) begin
      @(negedge clk);
      k++;
    end
    check(victim_idx == 3'd1, "R9 victim skips re-referenced frame", int'(victim_idx), 1);
    check(k == 10, "R9 latency", k, 10);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule